// File: doc/BRIEF.md
# Region Access Permission Checker

This block decides, one access at a time, whether a memory access may proceed. It compares the access address against up to sixteen configured protection regions. Each region has a power-of-two size, a base aligned to that size, an eight-way subregion disable mask, an access-permission code and a no-execute flag. The block reports an allow/fault decision together with the index of the region that decided it. The decision is computed combinationally and captured in an output register, so the result for an access presented in one cycle appears after the next rising clock edge.

Three global mode inputs shape the policy. The first switches checking on or off. The second chooses whether accesses made while a high-priority handler runs are checked or bypass the checker. The third chooses whether a privileged access that hits no region falls through to the default memory map. The region configuration comes from a separate register block as flat vectors, with one slice per region.

Top module: `regionGuard`

## Requirements
- R1: A region with size code S (5 bits, `regSize` slice) covers 2^(S+1) bytes. An address hits it when the address bits from bit S+1 upward equal the same bits of the region base. S=31 covers the whole 32-bit address space.
- R2: For S of 7 or more (256 bytes or larger), the region is split into eight equal subregions, and address bits [S:S-2] select subregion k. When bit k of the region's 8-bit subregion-off mask is set, the address does not hit that region.
- R3: For S below 7, the subregion-off mask has no effect on hits.
- R4: A region never hits any address if its enable bit is 0, if its S is below 4, or if its 3-bit permission code is 4 or 7.
- R5: When several regions hit, the one with the highest index decides the result. `hitValid` is 1 when any region hits and `hitIndex` gives the deciding region. When no region hits, `hitValid` and `hitIndex` are both 0.
- R6: The permission code of the deciding region (an instruction fetch counts as a read, `accWrite`=1 means write) is decoded as follows. 0 faults every access. 1 allows privileged read and write only. 2 allows privileged read and write plus unprivileged read. 3 allows everything. 5 allows privileged read only. 6 allows read at both privilege levels.
- R7: An instruction fetch (`accFetch`=1) whose deciding region has its no-execute bit set faults.
- R8: An access that hits no region is allowed only if it is privileged and `privBackground`=1. Otherwise it faults.
- R9: When `handlerGuard`=0, every access with `inHandler`=1 is allowed.
- R10: When `guardOn`=0, every access is allowed.
- R11: Outputs are registered, so the result for inputs present before a rising edge appears after that edge. While reset is active, `grantOk`, `hitValid` and `hitIndex` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accAddr | input | 32 | Access address |
| accWrite | input | 1 | 1 = write, 0 = read |
| accFetch | input | 1 | 1 = instruction fetch |
| accPriv | input | 1 | 1 = privileged access |
| inHandler | input | 1 | Access made while a high-priority handler runs |
| guardOn | input | 1 | Global checking enable |
| handlerGuard | input | 1 | 1 = check handler accesses too |
| privBackground | input | 1 | 1 = privileged misses use the default map |
| regBase | input | 512 | Region base addresses, 32 bits per region, region r at [32r+31:32r] |
| regSize | input | 80 | Size codes, 5 bits per region |
| regPerm | input | 48 | Permission codes, 3 bits per region |
| regNoExec | input | 16 | No-execute flag per region |
| regSubOff | input | 128 | Subregion-off masks, 8 bits per region |
| regOn | input | 16 | Region enable per region |
| grantOk | output | 1 | 1 = access allowed, 0 = fault |
| hitValid | output | 1 | Some region hit |
| hitIndex | output | 4 | Index of the deciding region |

## Verification
The assertions check, on every cycle, the policy rules that follow directly from inputs visible at the edge. Disabled checking and handler bypass must grant. No-execute fetches, permission code 0 and unprivileged misses must fault. A zero index must accompany a miss. Region geometry cannot be shown by a property alone: power-of-two sizes, subregion masking, the behaviour below 256 bytes, reserved codes and highest-index priority. The bench scenarios show these, both directed cases at region and subregion boundaries and a randomized sweep. In every case the outputs are compared with a behavioural model that uses arithmetic division, not bit masks.

// File: rtl/rgPkg.sv
package rgPkg;
  localparam int SIZE_W = 5;
  localparam int PERM_W = 3;
  localparam int SUB_N  = 8;

  // Policy strobes handed from control to datapath
  typedef struct packed {
    logic checkOn;  // region rules apply to this access
    logic bgAllow;  // a miss may fall through to the default map
  } guardStrobes_t;

  function automatic logic permits(input logic [PERM_W-1:0] code,
                                   input logic isWrite, input logic isPriv);
    logic ok;
    case (code)
      3'd1:    ok = isPriv;
      3'd2:    ok = isPriv || !isWrite;
      3'd3:    ok = 1'b1;
      3'd5:    ok = isPriv && !isWrite;
      3'd6:    ok = !isWrite;
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction
endpackage

// File: rtl/rgRegionMatch.sv
module rgRegionMatch
  import rgPkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [SIZE_W-1:0] sizeCode,
  input  logic [SUB_N-1:0]  subOff,
  input  logic [PERM_W-1:0] permCode,
  input  logic              enable,
  output logic              hit
);
  localparam logic [SIZE_W-1:0] MIN_SIZE = SIZE_W'(4);
  localparam logic [SIZE_W-1:0] SUB_MIN  = SIZE_W'(7);

  logic [SIZE_W:0]   shAmt;
  logic [ADDR_W-1:0] keepMask;
  logic [2:0]        subIdx;
  logic              sizeLegal, permLegal, subBlocked, tagEq;

  always_comb begin
    shAmt      = {1'b0, sizeCode} + (SIZE_W+1)'(1);
    keepMask   = {ADDR_W{1'b1}} << shAmt;
    tagEq      = (addr & keepMask) == (base & keepMask);
    subIdx     = 3'(addr >> (sizeCode - SIZE_W'(2)));
    subBlocked = (sizeCode >= SUB_MIN) && subOff[subIdx];
    sizeLegal  = sizeCode >= MIN_SIZE;
    permLegal  = (permCode != 3'd4) && (permCode != 3'd7);
    hit        = enable && sizeLegal && permLegal && tagEq && !subBlocked;
  end
endmodule

// File: rtl/rgControl.sv
module rgControl
  import rgPkg::*;
(
  input  logic          guardOn,
  input  logic          handlerGuard,
  input  logic          inHandler,
  input  logic          privBackground,
  input  logic          accPriv,
  output guardStrobes_t strobes
);
  always_comb begin
    strobes.checkOn = guardOn && !(inHandler && !handlerGuard);
    strobes.bgAllow = accPriv && privBackground;
  end
endmodule

// File: rtl/rgDatapath.sv
module rgDatapath
  import rgPkg::*;
#(
  parameter int NREG   = 16,
  parameter int ADDR_W = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        accAddr,
  input  logic                     accWrite,
  input  logic                     accFetch,
  input  logic                     accPriv,
  input  logic [NREG*ADDR_W-1:0]   regBase,
  input  logic [NREG*SIZE_W-1:0]   regSize,
  input  logic [NREG*PERM_W-1:0]   regPerm,
  input  logic [NREG-1:0]          regNoExec,
  input  logic [NREG*SUB_N-1:0]    regSubOff,
  input  logic [NREG-1:0]          regOn,
  input  guardStrobes_t            strobes,
  output logic                     grantOk,
  output logic                     hitValid,
  output logic [$clog2(NREG)-1:0]  hitIndex
);
  localparam int IDX_W = $clog2(NREG);

  logic [NREG-1:0]   hitVec;
  logic              anyHit;
  logic [IDX_W-1:0]  selIdx;
  logic [PERM_W-1:0] selPerm;
  logic              selNoExec, effWrite, regionOk, allowNext;

  for (genvar r = 0; r < NREG; r++) begin : gRegion
    rgRegionMatch #(.ADDR_W(ADDR_W)) uMatch (
      .addr     (accAddr),
      .base     (regBase[r*ADDR_W +: ADDR_W]),
      .sizeCode (regSize[r*SIZE_W +: SIZE_W]),
      .subOff   (regSubOff[r*SUB_N +: SUB_N]),
      .permCode (regPerm[r*PERM_W +: PERM_W]),
      .enable   (regOn[r]),
      .hit      (hitVec[r])
    );
  end

  // Ascending scan: the last (highest) hitting index wins
  always_comb begin
    anyHit = 1'b0;
    selIdx = '0;
    for (int r = 0; r < NREG; r++) begin
      if (hitVec[r]) begin
        anyHit = 1'b1;
        selIdx = IDX_W'(r);
      end
    end
  end

  always_comb begin
    selPerm   = regPerm[selIdx*PERM_W +: PERM_W];
    selNoExec = regNoExec[selIdx];
    effWrite  = accWrite && !accFetch;
    regionOk  = permits(selPerm, effWrite, accPriv) && !(accFetch && selNoExec);
    allowNext = !strobes.checkOn || (anyHit ? regionOk : strobes.bgAllow);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantOk  <= 1'b0;
      hitValid <= 1'b0;
      hitIndex <= '0;
    end else begin
      grantOk  <= allowNext;
      hitValid <= anyHit;
      hitIndex <= selIdx;
    end
  end

  // R5
  idle_index_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hitValid |-> hitIndex == '0);
  // R7
  fetch_noexec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.checkOn && anyHit && accFetch && selNoExec) |=> !grantOk);
  // R6
  perm_none_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.checkOn && anyHit && selPerm == 3'd0) |=> !grantOk);
  // R8
  unpriv_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.checkOn && !anyHit && !accPriv) |=> !grantOk);
endmodule

// File: rtl/regionGuard.sv
module regionGuard
  import rgPkg::*;
#(
  parameter int NREG   = 16,
  parameter int ADDR_W = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       accAddr,
  input  logic                    accWrite,
  input  logic                    accFetch,
  input  logic                    accPriv,
  input  logic                    inHandler,
  input  logic                    guardOn,
  input  logic                    handlerGuard,
  input  logic                    privBackground,
  input  logic [NREG*ADDR_W-1:0]  regBase,
  input  logic [NREG*SIZE_W-1:0]  regSize,
  input  logic [NREG*PERM_W-1:0]  regPerm,
  input  logic [NREG-1:0]         regNoExec,
  input  logic [NREG*SUB_N-1:0]   regSubOff,
  input  logic [NREG-1:0]         regOn,
  output logic                    grantOk,
  output logic                    hitValid,
  output logic [$clog2(NREG)-1:0] hitIndex
);
  guardStrobes_t strobes;

  rgControl uCtl (
    .guardOn        (guardOn),
    .handlerGuard   (handlerGuard),
    .inHandler      (inHandler),
    .privBackground (privBackground),
    .accPriv        (accPriv),
    .strobes        (strobes)
  );

  rgDatapath #(.NREG(NREG), .ADDR_W(ADDR_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .accAddr   (accAddr),
    .accWrite  (accWrite),
    .accFetch  (accFetch),
    .accPriv   (accPriv),
    .regBase   (regBase),
    .regSize   (regSize),
    .regPerm   (regPerm),
    .regNoExec (regNoExec),
    .regSubOff (regSubOff),
    .regOn     (regOn),
    .strobes   (strobes),
    .grantOk   (grantOk),
    .hitValid  (hitValid),
    .hitIndex  (hitIndex)
  );

  // R10
  off_allow_chk: assert property (@(posedge clk) disable iff (!rstN)
    !guardOn |=> grantOk);
  // R9
  handler_bypass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inHandler && !handlerGuard) |=> grantOk);
endmodule

// File: tb/sim_regionGuard.sv
module sim_regionGuard;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] accAddr = '0;
  logic accWrite = 0, accFetch = 0, accPriv = 0, inHandler = 0;
  logic guardOn = 0, handlerGuard = 1, privBackground = 0;
  logic [NR*32-1:0] regBase;
  logic [NR*5-1:0]  regSize;
  logic [NR*3-1:0]  regPerm;
  logic [NR-1:0]    regNoExec, regOn;
  logic [NR*8-1:0]  regSubOff;
  logic grantOk, hitValid;
  logic [3:0] hitIndex;

  logic [31:0] cBase [NR];
  logic [4:0]  cSize [NR];
  logic [2:0]  cPerm [NR];
  logic [7:0]  cSub  [NR];
  logic        cXn   [NR];
  logic        cOn   [NR];

  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int r = 0; r < NR; r++) begin
      regBase[r*32 +: 32] = cBase[r];
      regSize[r*5 +: 5]   = cSize[r];
      regPerm[r*3 +: 3]   = cPerm[r];
      regSubOff[r*8 +: 8] = cSub[r];
      regNoExec[r]        = cXn[r];
      regOn[r]            = cOn[r];
    end
  end

  regionGuard u0 (.*);

  // Behavioural reference: division-based geometry, table-based permissions
  task automatic model(output bit g, output bit hv, output int hi);
    longint unsigned a, bytes, sub;
    bit rd, ok;
    hv = 0; hi = 0;
    a = longint'(accAddr);
    for (int r = 0; r < NR; r++) begin
      if (!cOn[r] || cSize[r] < 4 || cPerm[r] == 4 || cPerm[r] == 7) continue;
      bytes = 64'd1 << (int'(cSize[r]) + 1);
      if ((a / bytes) != (longint'(cBase[r]) / bytes)) continue;
      if (cSize[r] >= 7) begin
        sub = (a % bytes) / (bytes / 8);
        if (cSub[r][int'(sub)]) continue;
      end
      hv = 1; hi = r;
    end
    rd = accFetch || !accWrite;
    if (!guardOn) g = 1;
    else if (inHandler && !handlerGuard) g = 1;
    else if (hv) begin
      case (cPerm[hi])
        1: ok = accPriv;
        2: ok = accPriv || rd;
        3: ok = 1;
        5: ok = accPriv && rd;
        6: ok = rd;
        default: ok = 0;
      endcase
      if (accFetch && cXn[hi]) ok = 0;
      g = ok;
    end else g = accPriv && privBackground;
  endtask

  task automatic step(input logic [31:0] ad, input bit wr, input bit fe,
                      input bit pr, input bit hd, input string tag);
    bit eg, ehv; int ehi;
    @(negedge clk);
    accAddr = ad; accWrite = wr; accFetch = fe; accPriv = pr; inHandler = hd;
    model(eg, ehv, ehi);
    @(posedge clk);
    @(negedge clk);
    total++;
    if (grantOk !== eg || hitValid !== ehv || int'(hitIndex) != ehi) begin
      bad++;
      $display("FAIL %s addr=%h grant=%0d/%0d hitValid=%0d/%0d hitIndex=%0d/%0d (actual/expected)",
               tag, ad, grantOk, eg, hitValid, ehv, hitIndex, ehi);
    end
  endtask

  task automatic setRegion(input int r, input logic [31:0] b, input logic [4:0] s,
                           input logic [2:0] p, input logic x, input logic [7:0] m);
    cBase[r] = b; cSize[r] = s; cPerm[r] = p; cXn[r] = x; cSub[r] = m; cOn[r] = 1;
  endtask

  initial begin
    for (int r = 0; r < NR; r++) begin
      cBase[r] = '0; cSize[r] = '0; cPerm[r] = '0; cSub[r] = '0; cXn[r] = 0; cOn[r] = 0;
    end
    // R11: reset state
    repeat (3) @(negedge clk);
    total++;
    if (grantOk !== 0 || hitValid !== 0 || hitIndex !== 0) begin
      bad++;
      $display("FAIL R11 reset grant=%0d hitValid=%0d hitIndex=%0d expected 0 0 0",
               grantOk, hitValid, hitIndex);
    end
    rstN = 1;
    guardOn = 1; handlerGuard = 1; privBackground = 0;
    setRegion(0, 32'h0800_0000, 5'h13, 3'd3, 0, 8'h00);
    setRegion(1, 32'h2000_0000, 5'h0E, 3'd2, 1, 8'h00);
    setRegion(2, 32'h4002_0000, 5'h0C, 3'd1, 1, 8'h00);
    setRegion(3, 32'h4002_2000, 5'h0B, 3'd6, 0, 8'hC0);
    setRegion(4, 32'h0800_0000, 5'h09, 3'd5, 0, 8'h00);
    setRegion(5, 32'h6000_0000, 5'h03, 3'd3, 0, 8'h00);
    setRegion(6, 32'h7000_0000, 5'h0B, 3'd7, 0, 8'h00);
    setRegion(7, 32'h9000_0000, 5'h05, 3'd3, 0, 8'hFF);
    setRegion(9, 32'hA000_0000, 5'h10, 3'd3, 0, 8'h00);
    cOn[9] = 0;

    step(32'h080F_FFFC, 0, 0, 0, 0, "R1");   // inside 1 MB region 0
    step(32'h0810_0000, 0, 0, 0, 0, "R1");   // one past the end: miss
    step(32'h0800_0010, 0, 0, 0, 0, "R5");   // region 4 overrides 0
    step(32'h0800_0010, 0, 0, 1, 0, "R5");
    step(32'h0800_03FC, 1, 0, 1, 0, "R6");   // code 5: privileged write faults
    step(32'h0800_0400, 1, 0, 0, 0, "R5");   // past region 4, back to region 0
    step(32'h2000_0100, 1, 0, 0, 0, "R6");   // code 2 unpriv write
    step(32'h2000_0100, 0, 0, 0, 0, "R6");   // code 2 unpriv read
    step(32'h4002_0040, 0, 0, 0, 0, "R6");   // code 1 unpriv read
    step(32'h4002_0040, 1, 0, 1, 0, "R6");   // code 1 priv write
    step(32'h4002_2004, 1, 0, 1, 0, "R6");   // code 6 write
    step(32'h2000_0000, 0, 1, 1, 0, "R7");   // fetch from no-exec
    step(32'h0800_1000, 1, 1, 0, 0, "R7");   // fetch, region 0 executable
    step(32'h4002_2C00, 0, 0, 0, 0, "R2");   // subregion 6 off
    step(32'h4002_2FFC, 0, 0, 1, 0, "R2");   // subregion 7 off
    step(32'h4002_2BFC, 0, 0, 0, 0, "R2");   // subregion 5 on
    step(32'h9000_0020, 0, 0, 0, 0, "R3");   // 64 B region, mask ignored
    step(32'h6000_0000, 0, 0, 0, 0, "R4");   // reserved size
    step(32'h7000_0000, 0, 0, 1, 0, "R4");   // code 7
    step(32'hA000_0000, 0, 0, 0, 0, "R4");   // disabled region
    privBackground = 1;
    step(32'h6000_0000, 1, 0, 1, 0, "R8");
    step(32'h6000_0000, 0, 0, 0, 0, "R8");
    handlerGuard = 0;
    step(32'h2000_0000, 1, 1, 0, 1, "R9");
    handlerGuard = 1;
    step(32'h2000_0000, 1, 0, 0, 1, "R9");
    guardOn = 0;
    step(32'h4002_0040, 1, 1, 0, 0, "R10");
    guardOn = 1;
    setRegion(15, 32'h0000_0000, 5'h1F, 3'd0, 0, 8'h00);
    step(32'hFFFF_FFF0, 0, 0, 1, 0, "R1");   // 4 GB region at top index
    step(32'h9000_0020, 0, 0, 1, 0, "R5");
    cOn[15] = 0;

    // Randomized sweep
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ad;
      int pick;
      if (i % 200 == 0) begin
        for (int r = 0; r < NR; r++) begin
          cSize[r] = 5'($urandom_range(2, 20));
          cBase[r] = $urandom & 32'h000F_FFE0;
          cPerm[r] = 3'($urandom_range(0, 7));
          cSub[r]  = 8'($urandom);
          cXn[r]   = 1'($urandom);
          cOn[r]   = ($urandom_range(0, 3) != 0);
        end
        guardOn = ($urandom_range(0, 7) != 0);
        handlerGuard = 1'($urandom);
        privBackground = 1'($urandom);
      end
      pick = $urandom_range(0, NR-1);
      ad = cBase[pick] + ($urandom & 32'h0000_3FFF);
      step(ad, 1'($urandom), 1'($urandom), 1'($urandom),
           ($urandom_range(0, 3) == 0), "R1 R2 R5 R6 sweep");
    end

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule